// File: doc/BRIEF.md
# Host I/O Port Write Snoop FIFO

This block watches host-side I/O write cycles, each presented as a one-cycle decoded strobe with a 16-bit port address and an 8-bit data byte. Writes to one or two programmable port addresses are captured into a small hardware FIFO. Each FIFO entry carries the data byte and a one-bit tag that records which address produced it. A double-word mode instead captures a window of four consecutive byte addresses and tags the last byte lane.

On the management side, software uses a byte-wide register port. Through it, software programs the match addresses, enables capture and interrupts, reads FIFO status, and pops bytes. The block also raises a sticky event when the host reset signal changes level. A single interrupt line combines FIFO-ready and host-reset events. Register reads return data combinationally in the cycle `reg_rd` is high, and their side effects take place at the next clock edge. The FIFO depth is set by the parameter `DEPTH`.

Top module: `io_snoop_fifo`

## Requirements
- R1: After reset, every register reads 0x00, the FIFO is empty and `irq` is low.
- R2: The first match address is held as a low byte at offset 0x10 and a high byte at 0x12. The second match address is held as a low byte at 0x02 and a high byte at 0x04. All four registers read back the value written.
- R3: The control register at offset 0x06 has these bits: bit 7 enables capture on the first address, bit 6 enables capture on the second address, bit 4 enables the host-reset interrupt, bit 3 enables the ready interrupt, and bit 2 selects double-word mode. A host write is captured only if its address equals an enabled match address. When both enabled addresses are equal, the first address wins.
- R4: The status register at offset 0x08 reads bit 7 = FIFO not empty, bit 5 = overflow, and bit 0 = tag of the head entry (0 for the first address, 1 for the second). All other bits read 0, and entries leave in arrival order.
- R5: Reading offset 0x0A returns the head byte and removes it from the FIFO. The same read on an empty FIFO returns 0x00 and changes nothing.
- R6: A capture that arrives while the FIFO holds `DEPTH` entries is dropped, and the sticky overflow bit is set. A status read clears the overflow bit only if the FIFO is empty at that read.
- R7: When a capture and a pop fall in the same cycle, both take effect, and the FIFO occupancy does not change.
- R8: In double-word mode, writes to the first address plus 0, 1, 2 and 3 are captured. Only the entry from the fourth byte lane is tagged 1. Bits 7 and 6 and the second address have no effect in this mode.
- R9: Bit 6 of the register at offset 0x0C is set when the host reset input changes level, through a two-stage synchronizer. Writing 1 to that bit clears it, and writing 0 leaves it set.
- R10: `irq` is high exactly when (bit 3 set and FIFO not empty) or (bit 4 set and the reset-change flag set).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host I/O write strobe, one cycle per write |
| host_addr | input | 16 | Host I/O port address |
| host_data | input | 8 | Host write data byte |
| host_rst_n | input | 1 | Host reset level, asynchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid while reg_rd is high |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle that occupancy never exceeds `DEPTH` and that a drop into a full FIFO raises overflow. They also check that overflow and the reset-change flag stay set until their own clear condition occurs, that a simultaneous capture and pop leave occupancy unchanged, that a lone pop reduces it by one, and that `irq` stays low with both interrupt enables clear.

Other behaviours need the bench's scenarios:
- address matching and first-address priority;
- tag values and arrival order;
- the window of four byte lanes in double-word mode, and that the second address is ignored there;
- the empty-read value;
- the exact point where overflow clears;
- the synchronizer latency of the reset-change flag.

// File: rtl/io_snoop_fifo.sv
module io_snoop_fifo #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [15:0] host_addr,
  input  logic [7:0]  host_data,
  input  logic        host_rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [4:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  output logic        irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [4:0] OFS_B_LO = 5'h02;
  localparam logic [4:0] OFS_B_HI = 5'h04;
  localparam logic [4:0] OFS_CTRL = 5'h06;
  localparam logic [4:0] OFS_STAT = 5'h08;
  localparam logic [4:0] OFS_DATA = 5'h0A;
  localparam logic [4:0] OFS_MISC = 5'h0C;
  localparam logic [4:0] OFS_A_LO = 5'h10;
  localparam logic [4:0] OFS_A_HI = 5'h12;

  logic [7:0]    a_lo, a_hi, b_lo, b_hi, en;
  logic [8:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          ovf, chg;
  logic [2:0]    hsync;

  wire [15:0] addr_a = {a_hi, a_lo};
  wire [15:0] addr_b = {b_hi, b_lo};
  wire        dw     = en[2];
  wire [15:0] off    = host_addr - addr_a;
  wire        dw_hit = dw && (off < 16'd4);
  wire        m_a    = !dw && en[7] && (host_addr == addr_a);
  wire        m_b    = !dw && en[6] && (host_addr == addr_b);
  wire        hit    = host_wr && (dw_hit || m_a || m_b);
  wire        tag    = dw ? (off == 16'd3) : !m_a;

  wire empty = (cnt == '0);
  wire full  = (cnt == CW'(DEPTH));
  wire push  = hit && !full;
  wire pop   = reg_rd && (reg_addr == OFS_DATA) && !empty;
  wire rd_stat = reg_rd && (reg_addr == OFS_STAT);
  wire chg_set = hsync[1] ^ hsync[2];
  wire chg_clr = reg_wr && (reg_addr == OFS_MISC) && reg_wdata[6];

  wire [8:0] head = empty ? 9'h000 : mem[rp];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_lo <= '0; a_hi <= '0; b_lo <= '0; b_hi <= '0; en <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_A_LO: a_lo <= reg_wdata;
        OFS_A_HI: a_hi <= reg_wdata;
        OFS_B_LO: b_lo <= reg_wdata;
        OFS_B_HI: b_hi <= reg_wdata;
        OFS_CTRL: en   <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {tag, host_data};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push) wp <= nxt(wp);
      if (pop)  rp <= nxt(rp);
      if (push && !pop)      cnt <= cnt + CW'(1);
      else if (pop && !push) cnt <= cnt - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                ovf <= 1'b0;
    else if (hit && full)      ovf <= 1'b1;
    else if (rd_stat && empty) ovf <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hsync <= '0;
      chg   <= 1'b0;
    end else begin
      hsync <= {hsync[1:0], host_rst_n};
      if (chg_set)      chg <= 1'b1;
      else if (chg_clr) chg <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_rd) begin
      case (reg_addr)
        OFS_A_LO: reg_rdata = a_lo;
        OFS_A_HI: reg_rdata = a_hi;
        OFS_B_LO: reg_rdata = b_lo;
        OFS_B_HI: reg_rdata = b_hi;
        OFS_CTRL: reg_rdata = en;
        OFS_STAT: reg_rdata = {!empty, 1'b0, ovf, 4'b0000, head[8]};
        OFS_DATA: reg_rdata = head[7:0];
        OFS_MISC: reg_rdata = {1'b0, chg, 6'b000000};
        default:  reg_rdata = 8'h00;
      endcase
    end
  end

  assign irq = (en[3] && !empty) || (en[4] && chg);
endmodule

// File: rtl/io_snoop_fifo_chk.sv
module io_snoop_fifo_chk #(
  parameter int DEPTH = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         hit,
  input logic                         push,
  input logic                         pop,
  input logic [$clog2(DEPTH+1)-1:0]   cnt,
  input logic                         ovf,
  input logic                         chg,
  input logic                         chg_clr,
  input logic                         rd_stat,
  input logic [7:0]                   en,
  input logic                         irq
);
  localparam int CW = $clog2(DEPTH + 1);

  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  a_r6_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && cnt == CW'(DEPTH)) |=> ovf);

  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !rd_stat) |=> ovf);

  a_r7_push_pop_same: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (cnt == $past(cnt)));

  a_r5_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !hit) |=> (cnt == $past(cnt) - CW'(1)));

  a_r9_chg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && !chg_clr) |=> chg);

  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!en[3] && !en[4]) |-> !irq);
endmodule

bind io_snoop_fifo io_snoop_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .hit(hit), .push(push), .pop(pop), .cnt(cnt),
  .ovf(ovf), .chg(chg), .chg_clr(chg_clr), .rd_stat(rd_stat), .en(en), .irq(irq)
);

// File: tb/io_snoop_fifo_tb_top.sv
`timescale 1ns/100ps
module io_snoop_fifo_tb_top;
  localparam int DEPTH = 8;
  localparam logic [4:0] B_LO = 5'h02, B_HI = 5'h04, CTRL = 5'h06, STAT = 5'h08;
  localparam logic [4:0] DATA = 5'h0A, MISC = 5'h0C, A_LO = 5'h10, A_HI = 5'h12;

  logic clk = 0, rst_n = 0, host_wr = 0, host_rst_n = 0, reg_wr = 0, reg_rd = 0;
  logic [15:0] host_addr = 0;
  logic [7:0]  host_data = 0, reg_wdata = 0, reg_rdata;
  logic [4:0]  reg_addr = 0;
  logic        irq;

  int total = 0, bad = 0;
  logic [15:0] m_a = 0, m_b = 0;
  logic [7:0]  m_en = 0;
  logic        m_ovf = 0;
  logic [8:0]  q[$];

  always #2.5 clk = ~clk;

  io_snoop_fifo #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_data(host_data), .host_rst_n(host_rst_n), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    case (a)
      A_LO: m_a[7:0] = d;  A_HI: m_a[15:8] = d;
      B_LO: m_b[7:0] = d;  B_HI: m_b[15:8] = d;
      CTRL: m_en = d;
      default: ;
    endcase
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  function automatic logic [1:0] predict(input logic [15:0] ad);
    logic [15:0] o;
    o = ad - m_a;
    if (m_en[2]) return {o < 16'd4, o == 16'd3};
    if (m_en[7] && ad == m_a) return 2'b10;
    if (m_en[6] && ad == m_b) return 2'b11;
    return 2'b00;
  endfunction

  // driver: predicts and queues the expected entry
  task automatic host_write(input logic [15:0] ad, input logic [7:0] d);
    logic [1:0] p;
    p = predict(ad);
    @(negedge clk); host_wr = 1; host_addr = ad; host_data = d;
    @(negedge clk); host_wr = 0;
    if (p[1]) begin
      if (q.size() < DEPTH) q.push_back({p[0], d});
      else m_ovf = 1;
    end
  endtask

  // monitor: reads status and data, compares against the scoreboard
  task automatic pop_check(input string req);
    logic [7:0] s, d, e;
    reg_read(STAT, s);
    e = {q.size() != 0, 1'b0, m_ovf, 4'b0, (q.size() != 0) ? q[0][8] : 1'b0};
    chk({req, " status"}, s, e);
    if (q.size() == 0) m_ovf = 0;
    reg_read(DATA, d);
    if (q.size() != 0) begin
      chk({req, " data"}, d, q[0][7:0]);
      void'(q.pop_front());
    end else chk({req, " empty data"}, d, 8'h00);
  endtask

  task automatic drain(input string req);
    while (q.size() != 0) pop_check(req);
    pop_check(req);
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog got=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    reg_read(STAT, v); chk("R1 stat", v, 8'h00);
    reg_read(CTRL, v); chk("R1 ctrl", v, 8'h00);
    reg_read(MISC, v); chk("R1 misc", v, 8'h00);
    reg_read(A_HI, v); chk("R1 addr", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 address registers
    reg_write(A_LO, 8'h80); reg_write(A_HI, 8'h00);
    reg_write(B_LO, 8'h84); reg_write(B_HI, 8'h12);
    reg_read(A_LO, v); chk("R2 a_lo", v, 8'h80);
    reg_read(B_LO, v); chk("R2 b_lo", v, 8'h84);
    reg_read(B_HI, v); chk("R2 b_hi", v, 8'h12);

    // R3/R4/R5 both channels, tags, order, ignored addresses
    reg_write(CTRL, 8'hC0);
    host_write(16'h0080, 8'h11);
    host_write(16'h1284, 8'h22);
    host_write(16'h0081, 8'h33);
    host_write(16'h0084, 8'h44);
    host_write(16'h0080, 8'h55);
    drain("R4 order");
    reg_read(DATA, v); chk("R5 empty read", v, 8'h00);

    // R3 disabled second address
    reg_write(CTRL, 8'h80);
    host_write(16'h1284, 8'h66);
    reg_read(STAT, v); chk("R3 disabled", v, 8'h00);

    // R3 priority when equal
    reg_write(B_LO, 8'h80); reg_write(B_HI, 8'h00); reg_write(CTRL, 8'hC0);
    host_write(16'h0080, 8'h77);
    drain("R3 priority");

    // R10 ready interrupt
    reg_write(CTRL, 8'h88);
    chk("R10 idle", {7'b0, irq}, 8'h00);
    host_write(16'h0080, 8'h99);
    chk("R10 ready", {7'b0, irq}, 8'h01);
    drain("R10 pop");
    chk("R10 cleared", {7'b0, irq}, 8'h00);

    // R6 overflow
    reg_write(CTRL, 8'h80);
    for (int i = 0; i < DEPTH + 2; i++) host_write(16'h0080, 8'(8'hA0 + i));
    reg_read(STAT, v); chk("R6 ovf nonempty", v, 8'hA0);
    drain("R6 drain");
    reg_read(STAT, v); chk("R6 ovf cleared", v, 8'h00);

    // R7 simultaneous capture and pop
    host_write(16'h0080, 8'hC1);
    @(negedge clk);
    host_wr = 1; host_addr = 16'h0080; host_data = 8'hC2;
    reg_rd = 1; reg_addr = DATA;
    #1 v = reg_rdata;
    @(negedge clk); host_wr = 0; reg_rd = 0;
    chk("R7 popped", v, q[0][7:0]);
    void'(q.pop_front()); q.push_back({1'b0, 8'hC2});
    drain("R7 after");

    // R8 double-word mode, second address and bits 7/6 ignored
    reg_write(B_LO, 8'h90); reg_write(CTRL, 8'h44);
    host_write(16'h0090, 8'hEE);
    host_write(16'h007F, 8'hEF);
    for (int i = 0; i < 4; i++) host_write(16'(16'h0080 + i), 8'(8'hD0 + i));
    host_write(16'h0084, 8'hD4);
    reg_read(STAT, v); chk("R8 head", v, 8'h80);
    drain("R8 dword");

    // R9/R10 host reset change
    reg_write(CTRL, 8'h10);
    @(negedge clk); host_rst_n = 1;
    @(negedge clk); chk("R9 sync delay", {7'b0, irq}, 8'h00);
    repeat (3) @(negedge clk);
    reg_read(MISC, v); chk("R9 set", v, 8'h40);
    chk("R10 reset irq", {7'b0, irq}, 8'h01);
    reg_write(MISC, 8'h00);
    reg_read(MISC, v); chk("R9 write0", v, 8'h40);
    reg_write(MISC, 8'h40);
    reg_read(MISC, v); chk("R9 clear", v, 8'h00);
    chk("R10 reset irq off", {7'b0, irq}, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule